// File: doc/BRIEF.md
# Serial-Number Arbitrated ID Assigner

This block gives a slave on a shared two-wire bus an 8-bit identity that is handed out at run time. A slave bit engine sits next to it. That engine reports start and stop conditions, one-cycle strobes for the rising and falling edges of SCL, the sampled SDA level, the decoded command code and the received ID byte. The block counts SCL rising edges from each start to locate itself in the frame. It drives SDA only through an open-drain pull-low output, `sda_pull`.

When an assign command arrives, every unassigned slave acknowledges the control byte and the ID byte. Each one then shifts out its fixed serial number onto the wired-AND line. A slave that releases the line for a 1 but then reads a 0 has lost. It releases the line for the rest of the frame. The one slave that survives all the serial bits loads the ID byte from the command, but only when the stop comes right after the master's no-acknowledge of the last serial byte.

A clear command sends every slave back to ID 00h and the unassigned state. Each slave then accepts assign commands again.

Top module: `sn_addr_assigner`

## Requirements
- R1: After reset, `dev_id` is 00h, `assigned` is 0 and `sda_pull` is 0.
- R2: The command code is sampled at the falling SCL edge after the 8th rising edge of the frame. The codes are 01 = assign and 10 = clear; any other code is ignored. In the 9th slot the block pulls SDA low for clear, and for assign only while unassigned. It does not pull for any other code.
- R3: When the block took part in the 9th slot, it also pulls SDA low in the 18th slot, which acknowledges the ID byte.
- R4: For assign, the serial number goes out MSB first, one bit in each of the eight data slots of each byte. Slot n of byte k is bit 19+9k+n. The block pulls low for a 0 and releases for a 1. It always releases in the master's acknowledge slot (bit 27+9k).
- R5: If the block releases for a 1 and samples SDA at 0 at the SCL rising edge, it drops out of the frame. It pulls no more for the rest of that frame and does not commit.
- R6: A slave that has not dropped out commits under these conditions: the stop arrives after exactly 72 rising edges (for six serial bytes), and SDA was high at the 72nd edge (no-acknowledge). On commit, the ID byte of the command loads into `dev_id` and `assigned` is set. Neither output changes before that stop.
- R7: While assigned, an assign command gets no pull from the block in any slot, and `dev_id` keeps its value.
- R8: The assign command is aborted with no ID committed in any of these cases: a stop at any other position, a master acknowledge at the 72nd edge, or a repeated start. A stop or a start releases SDA.
- R9: Clear pulls SDA low in the 9th, 18th and 27th slots. A stop after exactly 27 rising edges sets `dev_id` to 00h and `assigned` to 0, after which assign is accepted again.
- R10: A clear that ends with a stop at any position other than 27 rising edges changes neither `dev_id` nor `assigned`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_stb | input | 1 | Start (or repeated start) detected |
| stop_stb | input | 1 | Stop detected |
| scl_rise | input | 1 | SCL rising-edge strobe; SDA is sampled here |
| scl_fall | input | 1 | SCL falling-edge strobe; the drive for the next slot is set here |
| sda_in | input | 1 | Sampled SDA line level |
| cmd | input | 2 | Decoded command code (01 assign, 10 clear) |
| id_byte | input | ID_W | ID byte received after the control byte |
| sda_pull | output | 1 | 1 pulls SDA low |
| dev_id | output | ID_W | Current device ID |
| assigned | output | 1 | Device holds an assigned ID |

## Verification
`sda_pull` takes its new value on the clock edge that sees `scl_fall`. Loss of arbitration takes effect on the edge that sees `scl_rise`. `dev_id` and `assigned` change only on the edge that sees `stop_stb`. The bench waits a full clock after each of these strobes before it samples, on a falling clock edge. It reads the line level and each slave's pull at the falling clock edge just before it raises `scl_rise`, which is the value the design itself samples. Two instances with different serial numbers share one wired-AND line. The expected winner and the bit where the loser drops out come from comparing the two numbers in the bench.

// File: rtl/sn_addr_assigner.sv
module sn_addr_assigner #(
  parameter int ID_W = 8,
  parameter int SN_BYTES = 6,
  parameter logic [8*SN_BYTES-1:0] SERIAL = {SN_BYTES{8'hA5}}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_stb,
  input  logic            stop_stb,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            sda_in,
  input  logic [1:0]      cmd,
  input  logic [ID_W-1:0] id_byte,
  output logic            sda_pull,
  output logic [ID_W-1:0] dev_id,
  output logic            assigned
);
  localparam int SN_W     = 8 * SN_BYTES;
  localparam int CTRL_ACK = 9;
  localparam int ID_ACK   = 18;
  localparam int FIRST_SN = ID_ACK + 1;
  localparam int LAST_ACK = ID_ACK + 9 * SN_BYTES;
  localparam int CLR_ACK  = ID_ACK + 9;
  localparam int CW       = $clog2(LAST_ACK + 2);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [1:0] C_ASSIGN = 2'b01;
  localparam logic [1:0] C_CLEAR  = 2'b10;

  logic [CW-1:0]   cnt;
  logic [1:0]      cmd_q;
  logic [ID_W-1:0] id_q;
  logic            active, nack;

  int nb, p, slot, sidx;
  logic in_sn, data_slot, sn_bit, ok_cmd, pull_next, lose;
  logic [SN_W-1:0] sn_sh;

  always_comb begin
    nb        = int'(cnt) + 1;
    p         = nb - FIRST_SN;
    in_sn     = (nb >= FIRST_SN) && (nb < LAST_ACK);
    slot      = in_sn ? (p % 9) : 0;
    data_slot = in_sn && (slot < 8);
    sidx      = data_slot ? ((p / 9) * 8 + slot) : 0;
    sn_sh     = SERIAL >> (SN_W - 1 - sidx);
    sn_bit    = sn_sh[0];
  end

  assign ok_cmd = ((cmd == C_ASSIGN) && !assigned) || (cmd == C_CLEAR);
  assign lose   = active && (cmd_q == C_ASSIGN) && data_slot && !sda_pull && !sda_in;

  always_comb begin
    if (nb == CTRL_ACK)                           pull_next = ok_cmd;
    else if (!active)                             pull_next = 1'b0;
    else if (nb == ID_ACK)                        pull_next = 1'b1;
    else if ((cmd_q == C_ASSIGN) && data_slot)    pull_next = ~sn_bit;
    else if ((cmd_q == C_CLEAR) && nb == CLR_ACK) pull_next = 1'b1;
    else                                          pull_next = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= CMAX;
      cmd_q    <= '0;
      id_q     <= '0;
      active   <= 1'b0;
      nack     <= 1'b0;
      sda_pull <= 1'b0;
      dev_id   <= '0;
      assigned <= 1'b0;
    end else if (start_stb) begin
      cnt      <= '0;
      active   <= 1'b0;
      nack     <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_stb) begin
      if (active && cmd_q == C_ASSIGN && int'(cnt) == LAST_ACK && nack) begin
        dev_id   <= id_q;
        assigned <= 1'b1;
      end
      if (active && cmd_q == C_CLEAR && int'(cnt) == CLR_ACK) begin
        dev_id   <= '0;
        assigned <= 1'b0;
      end
      cnt      <= CMAX;
      active   <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      if (scl_rise) begin
        if (cnt != CMAX) cnt <= cnt + 1'b1;
        if (lose) active <= 1'b0;
        if (nb == LAST_ACK) nack <= sda_in;
      end
      if (scl_fall) begin
        sda_pull <= pull_next;
        if (nb == CTRL_ACK) begin
          cmd_q  <= cmd;
          active <= ok_cmd;
        end
        if (nb == ID_ACK) id_q <= id_byte;
      end
    end
  end
endmodule

module sn_addr_assigner_chk #(
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_stb,
  input logic            stop_stb,
  input logic            scl_rise,
  input logic            scl_fall,
  input logic            sda_pull,
  input logic [ID_W-1:0] dev_id,
  input logic            assigned
);
  AST_UNASSIGNED_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !assigned |-> (dev_id == '0)); // R1

  AST_ID_ONLY_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_stb |=> ($stable(assigned) && $stable(dev_id))); // R6

  AST_PULL_RISES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_fall || start_stb || stop_stb) |=> !$rose(sda_pull)); // R4

  AST_RELEASE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_stb || stop_stb) |=> !sda_pull); // R8

  AST_HOLD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && !scl_fall && !start_stb && !stop_stb) |=> $stable(sda_pull)); // R5
endmodule

bind sn_addr_assigner sn_addr_assigner_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .stop_stb(stop_stb),
  .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_pull(sda_pull),
  .dev_id(dev_id), .assigned(assigned)
);

// File: tb/sn_addr_assigner_tb.sv
module sn_addr_assigner_tb;
  localparam logic [47:0] SNA = 48'h3C5A_9012_F0E1;
  localparam logic [47:0] SNB = 48'h3C5A_9812_00FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_stb = 1'b0, stop_stb = 1'b0, scl_rise = 1'b0, scl_fall = 1'b0;
  logic m_sda = 1'b1;
  logic [1:0] cmd = 2'b00;
  logic [7:0] id_byte = 8'h00;
  logic pa, pb, asg_a, asg_b;
  logic [7:0] id_a, id_b;
  wire sda = m_sda & ~pa & ~pb;

  int n_tests = 0, n_fail = 0;
  int pa_tot, pb_tot, loser_late, ms_pull, loss_i;
  logic pa_s, pb_s, ack9, ack18, ack27;
  logic [47:0] cap, exp_cap;
  logic [7:0] pre_id_a;
  logic lose_b;

  always #4 clk = ~clk;

  sn_addr_assigner #(.SERIAL(SNA)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .stop_stb(stop_stb),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda), .cmd(cmd),
    .id_byte(id_byte), .sda_pull(pa), .dev_id(id_a), .assigned(asg_a));

  sn_addr_assigner #(.SERIAL(SNB)) u_peer (
    .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .stop_stb(stop_stb),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda), .cmd(cmd),
    .id_byte(id_byte), .sda_pull(pb), .dev_id(id_b), .assigned(asg_b));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_stb = 1'b1;
    @(negedge clk) start_stb = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_stb = 1'b1;
    @(negedge clk) stop_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic clk_bit(input logic m, output logic v);
    @(negedge clk) scl_fall = 1'b1;
    @(negedge clk) scl_fall = 1'b0; m_sda = m;
    @(negedge clk) v = sda; pa_s = pa; pb_s = pb;
    if (pa) pa_tot++;
    if (pb) pb_tot++;
    scl_rise = 1'b1;
    @(negedge clk) scl_rise = 1'b0; m_sda = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic v;
    for (int j = 7; j >= 0; j--) clk_bit(b[j], v);
  endtask

  task automatic assign_frame(input logic [7:0] idv, input int nbytes,
                              input logic final_m, input bit rstart);
    logic v;
    cmd = 2'b01; id_byte = idv;
    pa_tot = 0; pb_tot = 0; loser_late = 0; ms_pull = 0; cap = '0;
    pulse_start();
    send_byte(8'h61);
    clk_bit(1'b1, v); ack9 = v;
    send_byte(idv);
    clk_bit(1'b1, v); ack18 = v;
    for (int k = 0; k < nbytes; k++) begin
      for (int j = 0; j < 8; j++) begin
        clk_bit(1'b1, v);
        cap = {cap[46:0], v};
        if ((k * 8 + j) > loss_i && (lose_b ? pb_s : pa_s)) loser_late++;
      end
      clk_bit((k == nbytes - 1) ? final_m : 1'b0, v);
      if (pa_s || pb_s) ms_pull++;
    end
    pre_id_a = id_a;
    if (rstart) pulse_start();
    pulse_stop();
    cmd = 2'b00;
  endtask

  task automatic clear_frame(input bit full);
    logic v;
    cmd = 2'b10; id_byte = 8'hFF;
    pa_tot = 0; pb_tot = 0;
    pulse_start();
    send_byte(8'h66);
    clk_bit(1'b1, v); ack9 = v;
    send_byte(8'hFF);
    clk_bit(1'b1, v); ack18 = v;
    if (full) begin
      send_byte(8'h5C);
      clk_bit(1'b1, v); ack27 = v;
    end
    pulse_stop();
    cmd = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic v;
    lose_b = (SNA < SNB);
    exp_cap = lose_b ? SNA : SNB;
    loss_i = 48;
    for (int i = 47; i >= 0; i--)
      if (loss_i == 48 && SNA[i] != SNB[i]) loss_i = 47 - i;

    repeat (3) @(negedge clk);
    chk(id_a == 8'h00 && !asg_a && !pa, "R1 reset state", {id_a, asg_a, pa}, 10'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(id_b == 8'h00 && !asg_b && !pb, "R1 reset state peer", {id_b, asg_b, pb}, 10'h0);

    assign_frame(8'h5A, 6, 1'b1, 1'b0);
    chk(ack9 == 1'b0, "R2 control ack on assign", ack9, 0);
    chk(ack18 == 1'b0, "R3 ID byte ack", ack18, 0);
    chk(cap == exp_cap, "R4 serial MSB first wired-AND", cap, exp_cap);
    chk(ms_pull == 0, "R4 released in master ack slots", ms_pull, 0);
    chk(loser_late == 0, "R5 loser silent after loss", loser_late, 0);
    chk(pre_id_a == 8'h00, "R6 no commit before stop", pre_id_a, 0);
    chk(lose_b ? (asg_a && id_a == 8'h5A) : (asg_b && id_b == 8'h5A), "R6 winner commits", lose_b ? id_a : id_b, 8'h5A);
    chk(lose_b ? (!asg_b && id_b == 0) : (!asg_a && id_a == 0), "R5 loser not assigned", lose_b ? id_b : id_a, 0);

    assign_frame(8'h33, 6, 1'b1, 1'b0);
    chk((lose_b ? pa_tot : pb_tot) == 0, "R7 assigned device silent", lose_b ? pa_tot : pb_tot, 0);
    chk(cap == (lose_b ? SNB : SNA), "R4 lone serial out", cap, lose_b ? SNB : SNA);
    chk(ack9 == 1'b0, "R2 peer acks control", ack9, 0);
    chk(lose_b ? (asg_b && id_b == 8'h33) : (asg_a && id_a == 8'h33), "R6 second winner commits", lose_b ? id_b : id_a, 8'h33);
    chk((lose_b ? id_a : id_b) == 8'h5A, "R7 earlier ID kept", lose_b ? id_a : id_b, 8'h5A);

    assign_frame(8'h44, 6, 1'b1, 1'b0);
    chk(ack9 == 1'b1, "R7 no ack when all assigned", ack9, 1);
    chk(pa_tot + pb_tot == 0, "R7 no pull at all", pa_tot + pb_tot, 0);
    chk(id_a == (lose_b ? 8'h5A : 8'h33) && id_b == (lose_b ? 8'h33 : 8'h5A), "R7 IDs unchanged", {id_a, id_b}, lose_b ? 16'h5A33 : 16'h335A);

    cmd = 2'b11;
    pulse_start();
    send_byte(8'h67);
    clk_bit(1'b1, v);
    chk(v == 1'b1 && !pa_s && !pb_s, "R2 other code not acked", v, 1);
    pulse_stop();
    cmd = 2'b00;

    clear_frame(1'b0);
    chk(ack9 == 1'b0 && ack18 == 1'b0, "R9 clear acks control and ID", {ack9, ack18}, 0);
    chk(asg_a && asg_b && id_a != 0 && id_b != 0, "R10 aborted clear keeps IDs", {id_a, id_b}, 0);

    clear_frame(1'b1);
    chk(ack27 == 1'b0, "R9 clear data byte acked", ack27, 0);
    chk(!asg_a && !asg_b && id_a == 0 && id_b == 0, "R9 clear returns to 00h", {asg_a, asg_b, id_a, id_b}, 0);
    chk(!pa && !pb, "R8 released after stop", {pa, pb}, 0);

    assign_frame(8'h21, 3, 1'b0, 1'b0);
    chk(!asg_a && !asg_b, "R8 early stop aborts", {asg_a, asg_b}, 0);
    chk(!pa && !pb, "R8 bus released on abort", {pa, pb}, 0);

    assign_frame(8'h22, 6, 1'b0, 1'b0);
    chk(!asg_a && !asg_b, "R8 acked last byte aborts", {asg_a, asg_b}, 0);

    assign_frame(8'h23, 2, 1'b0, 1'b1);
    chk(!asg_a && !asg_b && id_a == 0 && id_b == 0, "R8 repeated start aborts", {asg_a, asg_b}, 0);

    assign_frame(8'h77, 6, 1'b1, 1'b0);
    chk(ack9 == 1'b0 && cap == exp_cap, "R9 assign accepted after clear", cap, exp_cap);
    chk(lose_b ? (asg_a && id_a == 8'h77 && !asg_b) : (asg_b && id_b == 8'h77 && !asg_a), "R6 commit after clear", lose_b ? id_a : id_b, 8'h77);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule